// File: doc/BRIEF.md
# Fine-Grained Thread Select Unit

This unit picks, every clock cycle, which of the four hardware threads of a single-issue, in-order core issues next. The core's pipeline has six stages: fetch, thread select, decode, execute, memory and writeback. This unit sits in the second of those stages. It rotates among the threads and skips any thread that cannot issue. A thread cannot issue while it is disabled, while it waits out the three-cycle shadow that follows one of its own loads or branches, or while one of its cache misses is outstanding.

Each thread has a small tracker with four named states. TS_READY means nothing is blocking the thread. TS_SHADOW means a 2-bit countdown is running after a load or branch. TS_MISS means a cache miss is pending. TS_BOTH means both apply. The tracker moves between states on these transitions: arm (the thread is granted with its long-op flag set), shadow expiry (the countdown reaches zero), miss start, and miss return. A return that arrives in the same cycle as a start wins. A rotating picker chooses among the ready, enabled threads. It starts its search at the thread after the one that last issued, and the grant appears in the same cycle as the eligibility it was computed from. When no thread can issue, the core idles for that cycle.

Top module: `fg_thread_select`

## Requirements
- R1: `grant` has at most one bit set in any cycle. `grant_vld` is high exactly when one bit of `grant` is set. Bit t of `grant` selects thread t.
- R2: The search order starts at the thread after the last thread that issued and wraps modulo 4. The first eligible thread in that order is granted. The last-issued pointer changes only in cycles where `grant_vld` is high.
- R3: When all four threads stay enabled and none issues a long op or misses, the grant changes every cycle: 0, 1, 2, 3, 0, and so on.
- R4: A thread granted in cycle c with its `long_op` bit high is not granted in cycles c+1, c+2 or c+3. From cycle c+4 it is eligible again.
- R5: A `miss_start` pulse for a thread in cycle c blocks that thread from cycle c+1 onward. A `miss_done` pulse in cycle d unblocks it from cycle d+1. If both pulses arrive for the same thread in the same cycle, the thread is not left pending.
- R6: A thread whose `thr_en` bit is low is never granted. Its shadow and miss tracking keep running while it is disabled.
- R7: When no thread is eligible, `grant` is zero, `grant_vld` is low and `core_idle` is high. In every other cycle `core_idle` is low.
- R8: Synchronous reset clears every countdown and every pending miss. It also points the search start at thread 0, so the first grant after reset goes to the lowest-numbered eligible thread.
- R9: A thread that is both in its shadow and waiting on a miss becomes eligible only after both conditions have cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thr_en | input | 4 | Per-thread enable |
| long_op | input | 4 | Per-thread flag: the thread's instruction is a load or branch if it is granted this cycle |
| miss_start | input | 4 | Per-thread pulse: a cache miss for this thread began |
| miss_done | input | 4 | Per-thread pulse: the fill for this thread returned |
| grant | output | 4 | One-hot select of the issuing thread |
| grant_vld | output | 1 | A thread issues this cycle |
| core_idle | output | 1 | No thread can issue this cycle |

## Verification
The bench targets the exact length of the long-op shadow. A countdown off by one would grant a thread in cycle c+3 or hold it back in cycle c+4. It also drives a miss start and a miss return together; a design that lets the start win would lock the thread out permanently. Other cases cover a thread held by both a shadow and a miss, the wrap of the rotation past thread 3, disabled threads lying in the search path, and the cycle when every thread is blocked. A design that moved the rotation pointer on idle cycles, or started the search at the last-issued thread instead of the one after it, would grant a different thread than the bench's reference model.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    // Per-thread blocking state
    typedef enum logic [1:0] {
        TS_READY  = 2'd0,
        TS_SHADOW = 2'd1,
        TS_MISS   = 2'd2,
        TS_BOTH   = 2'd3
    } thr_state_e;

endpackage

// File: rtl/tsel_thread_track.sv
module tsel_thread_track
    import tsel_pkg::*;
#(
    parameter int SHADOW_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic miss_start_i,
    input  logic miss_done_i,
    output logic ready_o
);

    localparam int              CNT_W    = $clog2(SHADOW_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SHADOW_CYC);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    thr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             miss_held, miss_next, shadow_next;

    // Event decode
    always_comb begin
        miss_held   = (state_q == TS_MISS) || (state_q == TS_BOTH);
        // a return in the same cycle as a start wins
        miss_next   = (miss_held || miss_start_i) && !miss_done_i;
        shadow_next = arm_i || (cnt_q > CNT_ONE);
        if (arm_i)
            cnt_d = CNT_LOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - CNT_ONE;
        else
            cnt_d = '0;
    end

    // Next-state selection
    always_comb begin
        unique case (state_q)
            TS_READY: begin
                if (arm_i)
                    state_d = miss_next ? TS_BOTH : TS_SHADOW;
                else
                    state_d = miss_next ? TS_MISS : TS_READY;
            end
            TS_SHADOW, TS_BOTH: begin
                if (shadow_next)
                    state_d = miss_next ? TS_BOTH : TS_SHADOW;
                else
                    state_d = miss_next ? TS_MISS : TS_READY;
            end
            TS_MISS: begin
                state_d = miss_next ? TS_MISS : TS_READY;
            end
            default: state_d = TS_READY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TS_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        ready_o = (state_q == TS_READY);
    end

    AST_ARM_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        arm_i |=> !ready_o); // R4

    AST_START_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (miss_start_i && !miss_done_i) |=> !ready_o); // R5

    AST_RETURN_WINS: assert property (@(posedge clk) disable iff (rst)
        miss_done_i |=> (state_q != TS_MISS && state_q != TS_BOTH)); // R5

    AST_BOTH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == TS_BOTH && !miss_done_i) |=> !ready_o); // R9

endmodule

// File: rtl/tsel_rr_pick.sv
module tsel_rr_pick #(
    parameter int NUM_THR = 4,
    parameter int IDX_W   = $clog2(NUM_THR)
) (
    input  logic [NUM_THR-1:0] elig_i,
    input  logic [IDX_W-1:0]   last_i,
    output logic [NUM_THR-1:0] gnt_o,
    output logic               any_o
);

    int   pos;
    logic found;

    // Search starts one past the last issuer and wraps
    always_comb begin
        gnt_o = '0;
        found = 1'b0;
        pos   = 0;
        for (int k = 1; k <= NUM_THR; k++) begin
            pos = (int'(last_i) + k) % NUM_THR;
            if (!found && elig_i[pos]) begin
                gnt_o[pos] = 1'b1;
                found      = 1'b1;
            end
        end
        any_o = found;
    end

endmodule

// File: rtl/fg_thread_select.sv
module fg_thread_select
    import tsel_pkg::*;
#(
    parameter int NUM_THR    = 4,
    parameter int SHADOW_CYC = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_THR-1:0] thr_en,
    input  logic [NUM_THR-1:0] long_op,
    input  logic [NUM_THR-1:0] miss_start,
    input  logic [NUM_THR-1:0] miss_done,
    output logic [NUM_THR-1:0] grant,
    output logic               grant_vld,
    output logic               core_idle
);

    localparam int               IDX_W     = $clog2(NUM_THR);
    localparam logic [IDX_W-1:0] LAST_INIT = IDX_W'(NUM_THR - 1);

    logic [NUM_THR-1:0] thr_ready;
    logic [NUM_THR-1:0] thr_elig;
    logic [NUM_THR-1:0] pick_gnt;
    logic               pick_any;
    logic [IDX_W-1:0]   last_q;
    logic [IDX_W-1:0]   gnt_idx;

    // One tracker per thread
    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
        tsel_thread_track #(
            .SHADOW_CYC(SHADOW_CYC)
        ) i_track (
            .clk         (clk),
            .rst         (rst),
            .arm_i       (pick_gnt[t] & long_op[t]),
            .miss_start_i(miss_start[t]),
            .miss_done_i (miss_done[t]),
            .ready_o     (thr_ready[t])
        );

        AST_LONG_SKIPS: assert property (@(posedge clk) disable iff (rst)
            (grant[t] && long_op[t]) |=> !grant[t]); // R4
    end

    assign thr_elig = thr_ready & thr_en;

    tsel_rr_pick #(
        .NUM_THR(NUM_THR),
        .IDX_W  (IDX_W)
    ) i_pick (
        .elig_i(thr_elig),
        .last_i(last_q),
        .gnt_o (pick_gnt),
        .any_o (pick_any)
    );

    // Index of the issuing thread
    always_comb begin
        gnt_idx = last_q;
        for (int t = 0; t < NUM_THR; t++) begin
            if (pick_gnt[t])
                gnt_idx = IDX_W'(t);
        end
    end

    // Rotation pointer
    always_ff @(posedge clk) begin
        if (rst)
            last_q <= LAST_INIT;
        else if (pick_any)
            last_q <= gnt_idx;
    end

    // Outputs
    always_comb begin
        grant     = pick_gnt;
        grant_vld = pick_any;
        core_idle = ~|thr_elig;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R1

    AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (rst)
        (grant & ~thr_en) == '0); // R6

    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        (grant & ~thr_ready) == '0); // R2

    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        core_idle |-> (grant == '0 && !grant_vld)); // R7

    AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !grant_vld |=> $stable(last_q)); // R2

endmodule

// File: tb/test_fg_thread_select.sv
`timescale 1ns/1ps
module test_fg_thread_select;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] en, lo, ms, md;
    logic [3:0] grant;
    logic       grant_vld, core_idle;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    // reference model state
    int cnt [4];
    bit mp  [4];
    int last;

    always #2 clk = ~clk;

    fg_thread_select i_fg_thread_select (
        .clk       (clk),
        .rst       (rst),
        .thr_en    (en),
        .long_op   (lo),
        .miss_start(ms),
        .miss_done (md),
        .grant     (grant),
        .grant_vld (grant_vld),
        .core_idle (core_idle)
    );

    function automatic logic [3:0] exp_grant();
        logic [3:0] g = '0;
        for (int k = 1; k <= 4; k++) begin
            int p = (last + k) % 4;
            if (g == '0 && en[p] && cnt[p] == 0 && !mp[p])
                g[p] = 1'b1;
        end
        return g;
    endfunction

    task automatic model_reset();
        for (int t = 0; t < 4; t++) begin
            cnt[t] = 0;
            mp[t]  = 1'b0;
        end
        last = 3;
    endtask

    task automatic step(input logic [3:0] e, input logic [3:0] l,
                        input logic [3:0] s, input logic [3:0] d,
                        input string tag);
        logic [3:0] eg;
        @(negedge clk);
        en = e; lo = l; ms = s; md = d;
        #1;
        eg = exp_grant();
        nchk++;
        if (grant !== eg || grant_vld !== (eg != '0) || core_idle !== (eg == '0)) begin
            nfail++;
            $display("FAIL %s: grant=%b vld=%b idle=%b expected grant=%b vld=%b idle=%b",
                     tag, grant, grant_vld, core_idle, eg, (eg != '0), (eg == '0));
        end
        @(posedge clk);
        for (int t = 0; t < 4; t++) begin
            if (eg[t] && l[t])
                cnt[t] = 3;
            else if (cnt[t] > 0)
                cnt[t] = cnt[t] - 1;
            mp[t] = (mp[t] || s[t]) && !d[t];
            if (eg[t])
                last = t;
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        rst = 1'b1; en = '0; lo = '0; ms = '0; md = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R8 / R7: after reset nothing enabled -> idle, then thread 0 first
        step(4'h0, 4'h0, 4'h0, 4'h0, "R7 reset idle");
        step(4'hF, 4'h0, 4'h0, 4'h0, "R8 first grant thread 0");
        // R3: plain rotation with wrap
        for (int i = 0; i < 8; i++) step(4'hF, 4'h0, 4'h0, 4'h0, "R3 rotation");
        // R4: every thread issues a long op, then shadow expiry
        for (int i = 0; i < 4; i++) step(4'hF, 4'hF, 4'h0, 4'h0, "R4 arm all");
        for (int i = 0; i < 6; i++) step(4'hF, 4'h0, 4'h0, 4'h0, "R4 shadow expiry");
        // R4 / R7: single thread, long op leaves three idle cycles
        step(4'h4, 4'h4, 4'h0, 4'h0, "R4 lone arm");
        for (int i = 0; i < 3; i++) step(4'h4, 4'h0, 4'h0, 4'h0, "R7 shadow idle");
        step(4'h4, 4'h0, 4'h0, 4'h0, "R4 eligible at c+4");
        // R5: miss start blocks thread 0, return reopens it
        step(4'hF, 4'h0, 4'h1, 4'h0, "R5 miss start");
        for (int i = 0; i < 5; i++) step(4'hF, 4'h0, 4'h0, 4'h0, "R5 miss pending skip");
        step(4'hF, 4'h0, 4'h0, 4'h1, "R5 miss return");
        for (int i = 0; i < 4; i++) step(4'hF, 4'h0, 4'h0, 4'h0, "R5 after return");
        // R5: start and return in the same cycle on thread 1
        step(4'h2, 4'h0, 4'h2, 4'h2, "R5 start+return");
        step(4'h2, 4'h0, 4'h0, 4'h0, "R5 return wins");
        // R9: thread 3 in shadow and miss together
        step(4'h8, 4'h8, 4'h8, 4'h0, "R9 arm with miss");
        for (int i = 0; i < 6; i++) step(4'h8, 4'h0, 4'h0, 4'h0, "R9 both held");
        step(4'h8, 4'h0, 4'h0, 4'h8, "R9 return");
        step(4'h8, 4'h0, 4'h0, 4'h0, "R9 reopened");
        // R6: disabled threads in the search path
        for (int i = 0; i < 8; i++) step(4'h5, 4'h0, 4'h0, 4'h0, "R6 disabled skip");
        step(4'h0, 4'h0, 4'h0, 4'h0, "R6 R7 none enabled");
        // R1 R2: constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] e, l, s, d;
            for (int t = 0; t < 4; t++) begin
                e[t] = ($urandom % 8) != 0;
                l[t] = ($urandom % 3) == 0;
                s[t] = ($urandom % 16) == 0;
                d[t] = ($urandom % 4) == 0;
            end
            step(e, l, s, d, "R1 R2 random");
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule